// File: doc/BRIEF.md
# Error-Check Packet Presence and Unknown-Status Flag Merge

This block watches a stream of 10-bit video words, one field at a time. It looks for an error-check packet, which it recognises by the header words 000h, 3FFh, 3FFh and 1F4h in consecutive words. A packet only counts when the first header word falls on the line and word position set by the `exp_line` and `exp_word` inputs. The block keeps its own line and word counters. A `field_start` pulse on the first word of each field clears them, and a `line_end` pulse on the last word of each line moves them to the next line.

When a packet counts, the block reads three flag words at fixed distances after the 1F4h word. These give the unknown-error-status bit (UES) and the CRC-valid bit for the ancillary, active-picture and full-field regions. At each `field_start` the block registers its results for the field that has just ended, and holds them for the whole of the next field:
- a "no packet" flag, which is the NAND of "header found" and "header at the expected position";
- one merged UES flag per region.

Top module: `edh_presence_ues`

## Requirements
- R1: While reset is high, and until the first field boundary after it, `no_edh` reads 1 and all three UES outputs read 1.
- R2: Four consecutive words 000h, 3FFh, 3FFh, 1F4h in one field, with the 000h word at (`exp_line`, `exp_word`), make `no_edh` 0 for that field.
- R3: A correct header whose first word is at any other position, or whose last word does not arrive within the field, leaves `no_edh` at 1.
- R4: If any one of the four header words differs, at the expected position, `no_edh` stays 1.
- R5: The outputs change only on the clock edge that samples `field_start` high. They then hold the results of the field that has just ended.
- R6: The result is per field. A field without a packet reports `no_edh` 1 even when the field before it had one.
- R7: The word that carries `field_start` is at line 0, word 0. The word after a `line_end` word is at word 0 of the next line. Every other word is one word further along the same line.
- R8: The flag words sit 9 (ancillary), 10 (active picture) and 11 (full field) words after the 1F4h word. In each flag word, bit 4 is UES and bit 5 is the valid bit. Each region's output equals that region's UES OR the inverse of its valid bit.
- R9: In a field with no counted packet, all three UES outputs are 1.
- R10: If a packet counts but a region's flag word does not arrive before the field ends, that region's UES output is 1. A flag word in the last word of the field is still used.
- R11: A header split across a field boundary is not counted in either field.
- R12: A header may cross a line end. The position that counts is that of its 000h word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Incoming video word |
| field_start | input | 1 | High on the first word of a field |
| line_end | input | 1 | High on the last word of a line |
| exp_line | input | LINE_W | Expected line of the first header word |
| exp_word | input | WORD_W | Expected word offset of the first header word |
| no_edh | output | 1 | Previous field had no counted packet |
| ues_anc | output | 1 | Merged ancillary unknown-status flag |
| ues_ap | output | 1 | Merged active-picture unknown-status flag |
| ues_ff | output | 1 | Merged full-field unknown-status flag |

## Verification
Two events can fall on the same clock edge: a region's flag word is captured, and the field's results are latched at the boundary. The bench provokes this by ending a field so that the full-field flag word is its last word. It then checks that the flag was used. It also ends a field one word earlier and checks that the full-field output is forced high. A header split by a field boundary, and a header that starts on the boundary word itself, are also sent. Each is judged by the outputs read after the next boundary.

// File: rtl/edh_pres_pkg.sv
package edh_pres_pkg;

    localparam int SYM_W   = 10;
    localparam int HDR_LEN = 4;

    typedef logic [SYM_W-1:0] sym_t;

    // Header symbol by index, first word first
    function automatic sym_t hdr_sym(input int idx);
        case (idx)
            0:       return 10'h000;
            1, 2:    return 10'h3FF;
            default: return 10'h1F4;
        endcase
    endfunction

    typedef enum logic [1:0] {
        RGN_ANC = 2'd0,
        RGN_AP  = 2'd1,
        RGN_FF  = 2'd2
    } rgn_e;

    localparam int NUM_RGN   = 3;
    localparam int FLAG_BASE = 9;   // distance of the ancillary flag word after the id word
    localparam int OFS_LAST  = FLAG_BASE + NUM_RGN - 1;
    localparam int OFS_W     = $clog2(OFS_LAST + 1);
    localparam int UES_POS   = 4;
    localparam int VLD_POS   = 5;

    typedef struct packed {
        logic got;
        logic ues;
        logic vld;
    } rgn_flag_t;

    function automatic int flag_ofs(input rgn_e r);
        return FLAG_BASE + int'(r);
    endfunction

    function automatic logic ues_merge(input rgn_flag_t f, input logic present);
        return !present || !f.got || f.ues || !f.vld;
    endfunction

endpackage

// File: rtl/edh_pos_tracker.sv
module edh_pos_tracker #(
    parameter int LINE_W = 11,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  logic              line_end,
    output logic [LINE_W-1:0] pos_line,
    output logic [WORD_W-1:0] pos_word
);

    logic [LINE_W-1:0] line_q;
    logic [WORD_W-1:0] word_q;

    // Position of the word present this cycle
    always_comb begin
        pos_line = field_start ? '0 : line_q;
        pos_word = field_start ? '0 : word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            word_q <= '0;
        end else if (line_end) begin
            line_q <= pos_line + LINE_W'(1);
            word_q <= '0;
        end else begin
            line_q <= pos_line;
            word_q <= pos_word + WORD_W'(1);
        end
    end

endmodule

// File: rtl/edh_hdr_detect.sv
module edh_hdr_detect
    import edh_pres_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  sym_t              din,
    input  logic [LINE_W-1:0] pos_line,
    input  logic [WORD_W-1:0] pos_word,
    input  logic [LINE_W-1:0] exp_line,
    input  logic [WORD_W-1:0] exp_word,
    output logic              hdr_found,
    output logic              at_expected
);

    localparam int DEPTH = HDR_LEN - 1;

    sym_t              h_sym  [DEPTH];
    logic              h_vld  [DEPTH];
    logic [LINE_W-1:0] h_line [DEPTH];
    logic [WORD_W-1:0] h_word [DEPTH];

    // Stage 0 holds the previous word, the last stage the oldest
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_sym[k]  <= '0;
                    h_vld[k]  <= 1'b0;
                    h_line[k] <= '0;
                    h_word[k] <= '0;
                end else begin
                    h_sym[k]  <= din;
                    h_vld[k]  <= 1'b1;
                    h_line[k] <= pos_line;
                    h_word[k] <= pos_word;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_sym[k]  <= '0;
                    h_vld[k]  <= 1'b0;
                    h_line[k] <= '0;
                    h_word[k] <= '0;
                end else begin
                    h_sym[k]  <= h_sym[k-1];
                    h_vld[k]  <= h_vld[k-1] && !field_start;
                    h_line[k] <= h_line[k-1];
                    h_word[k] <= h_word[k-1];
                end
            end
        end
    end

    always_comb begin
        hdr_found = !field_start && (din == hdr_sym(DEPTH));
        for (int k = 0; k < DEPTH; k++) begin
            hdr_found = hdr_found && h_vld[k] && (h_sym[k] == hdr_sym(DEPTH - 1 - k));
        end
        at_expected = (h_line[DEPTH-1] == exp_line) && (h_word[DEPTH-1] == exp_word);
    end

endmodule

// File: rtl/edh_flag_capture.sv
module edh_flag_capture
    import edh_pres_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     field_start,
    input  sym_t                     din,
    input  logic                     pkt_start,
    output rgn_flag_t [NUM_RGN-1:0]  rflag
);

    logic             armed;
    logic [OFS_W-1:0] ofs;

    // ofs is the distance of the current word from the id word
    always_ff @(posedge clk) begin
        if (rst || field_start) begin
            armed <= 1'b0;
            ofs   <= '0;
        end else if (pkt_start) begin
            armed <= 1'b1;
            ofs   <= OFS_W'(1);
        end else if (armed) begin
            ofs <= ofs + OFS_W'(1);
            if (ofs == OFS_W'(OFS_LAST)) begin
                armed <= 1'b0;
            end
        end
    end

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
        localparam int MY_OFS = flag_ofs(rgn_e'(r));
        rgn_flag_t fl_q;

        always_ff @(posedge clk) begin
            if (rst || field_start || pkt_start) begin
                fl_q <= '{got: 1'b0, ues: 1'b0, vld: 1'b0};
            end else if (armed && ofs == OFS_W'(MY_OFS)) begin
                fl_q <= '{got: 1'b1, ues: din[UES_POS], vld: din[VLD_POS]};
            end
        end

        assign rflag[r] = fl_q;
    end

endmodule

// File: rtl/edh_presence_ues.sv
module edh_presence_ues
    import edh_pres_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        din,
    input  logic              field_start,
    input  logic              line_end,
    input  logic [LINE_W-1:0] exp_line,
    input  logic [WORD_W-1:0] exp_word,
    output logic              no_edh,
    output logic              ues_anc,
    output logic              ues_ap,
    output logic              ues_ff
);

    logic [LINE_W-1:0]        pos_line;
    logic [WORD_W-1:0]        pos_word;
    logic                     hdr_found;
    logic                     at_expected;
    logic                     pkt_hit;
    rgn_flag_t [NUM_RGN-1:0]  cap;

    logic                     hdr_seen_q;
    logic                     placed_q;
    logic                     pkt_seen;
    logic                     no_edh_q;
    logic [NUM_RGN-1:0]       ues_q;
    logic [NUM_RGN-1:0]       ues_next;

    edh_pos_tracker #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_pos (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .line_end    (line_end),
        .pos_line    (pos_line),
        .pos_word    (pos_word)
    );

    edh_hdr_detect #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_hdr (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .din         (din),
        .pos_line    (pos_line),
        .pos_word    (pos_word),
        .exp_line    (exp_line),
        .exp_word    (exp_word),
        .hdr_found   (hdr_found),
        .at_expected (at_expected)
    );

    assign pkt_hit = hdr_found && at_expected;

    edh_flag_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .din         (din),
        .pkt_start   (pkt_hit),
        .rflag       (cap)
    );

    assign pkt_seen = hdr_seen_q && placed_q;

    always_comb begin
        for (int r = 0; r < NUM_RGN; r++) begin
            ues_next[r] = ues_merge(cap[r], pkt_seen);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_seen_q <= 1'b0;
            placed_q   <= 1'b0;
            no_edh_q   <= 1'b1;
            ues_q      <= '1;
        end else if (field_start) begin
            no_edh_q   <= ~(hdr_seen_q & placed_q);
            ues_q      <= ues_next;
            hdr_seen_q <= 1'b0;
            placed_q   <= 1'b0;
        end else if (pkt_hit) begin
            hdr_seen_q <= 1'b1;
            placed_q   <= 1'b1;
        end
    end

    assign no_edh  = no_edh_q;
    assign ues_anc = ues_q[RGN_ANC];
    assign ues_ap  = ues_q[RGN_AP];
    assign ues_ff  = ues_q[RGN_FF];

endmodule

// File: rtl/edh_presence_ues_chk.sv
module edh_presence_ues_chk
    import edh_pres_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int WORD_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    field_start,
    input logic                    line_end,
    input logic [LINE_W-1:0]       pos_line,
    input logic [WORD_W-1:0]       pos_word,
    input logic                    pkt_seen,
    input rgn_flag_t [NUM_RGN-1:0] cap,
    input logic                    no_edh,
    input logic                    ues_anc,
    input logic                    ues_ap,
    input logic                    ues_ff
);

    logic [NUM_RGN-1:0] ues_o;
    logic [NUM_RGN-1:0] c_got, c_ues, c_vld;

    assign ues_o = {ues_ff, ues_ap, ues_anc};

    always_comb begin
        for (int r = 0; r < NUM_RGN; r++) begin
            c_got[r] = cap[r].got;
            c_ues[r] = cap[r].ues;
            c_vld[r] = cap[r].vld;
        end
    end

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> ($stable(no_edh) && $stable(ues_o))); // R5

    AST_ABSENT_ALL_UES: assert property (@(posedge clk) disable iff (rst)
        no_edh |-> (ues_o == '1)); // R9

    AST_ABSENT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (field_start && !pkt_seen) |=> no_edh); // R4

    AST_UES_MERGE: assert property (@(posedge clk) disable iff (rst)
        (field_start && pkt_seen) |=> (!no_edh && ues_o == $past(~c_got | c_ues | ~c_vld))); // R8

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !field_start && !$past(line_end))
        |-> (pos_word == WORD_W'($past(pos_word) + WORD_W'(1)) && pos_line == $past(pos_line))); // R7

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !field_start && $past(line_end))
        |-> (pos_word == '0 && pos_line == LINE_W'($past(pos_line) + LINE_W'(1)))); // R7

endmodule

bind edh_presence_ues edh_presence_ues_chk #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .field_start (field_start),
    .line_end    (line_end),
    .pos_line    (pos_line),
    .pos_word    (pos_word),
    .pkt_seen    (pkt_seen),
    .cap         (cap),
    .no_edh      (no_edh),
    .ues_anc     (ues_anc),
    .ues_ap      (ues_ap),
    .ues_ff      (ues_ff)
);

// File: tb/edh_presence_ues_bench.sv
module edh_presence_ues_bench;

    localparam int LW       = 4;
    localparam int WW       = 6;
    localparam int LINE_LEN = 20;
    localparam int FULL     = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [9:0]    din = 10'h200;
    logic          field_start = 1'b0;
    logic          line_end = 1'b0;
    logic [LW-1:0] exp_line = '0;
    logic [WW-1:0] exp_word = '0;
    logic          no_edh, ues_anc, ues_ap, ues_ff;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [3:0] prev_exp = 4'b1111;
    string prev_tag = "R1";

    always #5 clk = ~clk;

    edh_presence_ues #(.LINE_W(LW), .WORD_W(WW)) u_edh_presence_ues (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .field_start (field_start),
        .line_end    (line_end),
        .exp_line    (exp_line),
        .exp_word    (exp_word),
        .no_edh      (no_edh),
        .ues_anc     (ues_anc),
        .ues_ap      (ues_ap),
        .ues_ff      (ues_ff)
    );

    function automatic logic [9:0] hsym(input int k);
        case (k)
            0:       return 10'h000;
            1, 2:    return 10'h3FF;
            default: return 10'h1F4;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: {no_edh,ff,ap,anc} got %b expected %b", tag, act, expv);
        end
    endtask

    // One field: optional header tail at the start, optional packet with its
    // first header word at (hl,hw), one corrupted header word (bad<4)
    task automatic send_field(input int nwords, input int hl, input int hw,
                              input bit put, input int bad,
                              input logic [2:0] ui, input logic [2:0] vi,
                              input int lead, input string tag);
        int  p0;
        bit  present;
        logic [3:0] e;
        p0 = hl * LINE_LEN + hw;
        for (int i = 0; i < nwords; i++) begin
            logic [9:0] w;
            int k;
            w = 10'h200;
            if (i < lead) w = hsym(4 - lead + i);
            k = i - p0;
            if (put && k >= 0 && k < 4) begin
                w = hsym(k);
                if (bad == k) w = w ^ 10'h001;
            end else if (put && k >= 4 && k <= 14) begin
                w = 10'h040;
                for (int r = 0; r < 3; r++) begin
                    if (k - 3 == 9 + r)
                        w = 10'((int'(vi[r]) << 5) | (int'(ui[r]) << 4) | 1);
                end
            end
            din = w;
            field_start = (i == 0);
            line_end = ((i % LINE_LEN) == LINE_LEN - 1);
            if (i == nwords - 1 && i > 0)
                chk("R5 hold", {no_edh, ues_ff, ues_ap, ues_anc}, prev_exp);
            @(negedge clk);
            if (i == 0)
                chk(prev_tag, {no_edh, ues_ff, ues_ap, ues_anc}, prev_exp);
        end
        present = put && bad >= 4 && (p0 + 3 < nwords)
                  && hl == int'(exp_line) && hw == int'(exp_word);
        e[3] = !present;
        for (int r = 0; r < 3; r++) begin
            bit got;
            got = (p0 + 3 + 9 + r) < nwords;
            e[r] = !present || !got || ui[r] || !vi[r];
        end
        prev_exp = e;
        prev_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {no_edh, ues_ff, ues_ap, ues_anc}, 4'b1111);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {no_edh, ues_ff, ues_ap, ues_anc}, 4'b1111);

        // Position sweep: only (1,5) counts
        exp_line = 4'd1; exp_word = 6'd5;
        for (int hl = 0; hl < 4; hl++) begin
            for (int hw = 0; hw < LINE_LEN; hw++) begin
                send_field(FULL, hl, hw, 1'b1, 4, 3'b000, 3'b111, 0,
                           (hl == 1 && hw == 5) ? "R2" : "R3");
            end
        end

        // Flag merge: all UES / valid combinations
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                send_field(FULL, 1, 5, 1'b1, 4, 3'(u), 3'(v), 0, "R8");
            end
        end

        // One corrupted header word
        for (int b = 0; b < 4; b++) begin
            send_field(FULL, 1, 5, 1'b1, b, 3'b000, 3'b111, 0, "R4");
        end

        // Per-field behaviour and absent packet
        send_field(FULL, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R6");
        send_field(FULL, 0, 0, 1'b0, 4, 3'b000, 3'b111, 0, "R6");
        send_field(FULL, 0, 0, 1'b0, 4, 3'b000, 3'b111, 0, "R9");

        // Header across a line end
        exp_line = 4'd0; exp_word = 6'd18;
        send_field(FULL, 0, 18, 1'b1, 4, 3'b010, 3'b111, 0, "R12");
        exp_line = 4'd2; exp_word = 6'd19;
        send_field(FULL, 2, 19, 1'b1, 4, 3'b000, 3'b011, 0, "R12");

        // Position counting from the boundary word and across lines
        exp_line = 4'd0; exp_word = 6'd0;
        send_field(FULL, 0, 0, 1'b1, 4, 3'b000, 3'b111, 0, "R7");
        exp_line = 4'd3; exp_word = 6'd0;
        send_field(FULL, 3, 0, 1'b1, 4, 3'b001, 3'b111, 0, "R7");
        send_field(FULL, 2, 0, 1'b1, 4, 3'b000, 3'b111, 0, "R7");

        // Field ends around the flag words (first word at 25, id word at 28)
        exp_line = 4'd1; exp_word = 6'd5;
        send_field(40, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R10");
        send_field(39, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R10");
        send_field(37, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R10");
        send_field(29, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R10");
        send_field(28, 1, 5, 1'b1, 4, 3'b000, 3'b111, 0, "R3");

        // Header split by a field boundary
        exp_line = 4'd3; exp_word = 6'd18;
        send_field(FULL, 3, 18, 1'b1, 4, 3'b000, 3'b111, 0, "R11");
        send_field(FULL, 0, 0, 1'b0, 4, 3'b000, 3'b111, 2, "R11");
        exp_line = 4'd0; exp_word = 6'd0;
        send_field(FULL, 0, 0, 1'b0, 4, 3'b000, 3'b111, 3, "R11");

        send_field(1, 0, 0, 1'b0, 4, 3'b000, 3'b111, 0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule